// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block keeps four 16-bit segment bases and turns a segment/offset pair into a 20-bit physical byte address. The chosen base is taken as the address of the lowest byte of a 64 KB window. It is scaled by sixteen, which is a left shift of four bit positions, and the offset is added to it. Any carry beyond the top address bit is dropped, so the address space is a 1 MB ring. Segments are not checked for overlap. Two bases may cover the same physical bytes, and two registers may hold the same value.

The address path is combinational. A change on the segment select or the offset shows on `phys_addr` and `seg_value` in the same cycle, with no handshake. The bases are updated through a plain synchronous write port. A write lands at the rising clock edge, so a read of the same register in the write cycle still returns the old value. Control pins are plain level signals. The block has no stream interface, so there is no back-pressure to honour.

Top module: `seg_addr_gen`

## Requirements
- R1: While `rst_n` is low, the code base (select 01) holds FFFFh and the extra, stack and data bases (selects 00, 10, 11) hold 0000h.
- R2: The select encoding is 00 = extra, 01 = code, 10 = stack, 11 = data. `seg_value` shows the base chosen by `rd_sel` in the same cycle.
- R3: `phys_addr` equals (base << 4) + `offset`, reduced modulo 2^20. It responds combinationally to `rd_sel`, `offset` and the stored bases.
- R4: A carry out of bit 19 is discarded. Base FFFFh with offset 0010h gives 00000h, and base FFFFh with offset FFFFh gives 0FFEFh.
- R5: When `wr_en` is high at a rising edge, the base chosen by `wr_sel` takes `wr_data`. The new value is visible from the next cycle and not in the write cycle.
- R6: When `wr_en` is low at a rising edge, no base changes, whatever `wr_sel` and `wr_data` carry.
- R7: A write changes only the base named by `wr_sel`. The other three keep their values.
- R8: Base 1005h with offset 5555h gives 155A5h, and base 548Bh with offset 1242h gives 55AF2h.
- R9: Bases may overlap. Two registers that hold the same value give identical addresses for the same offset, and no exclusivity check blocks this.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Enables a base write at the next rising edge |
| wr_sel | input | 2 | Base chosen for the write (encoding as in R2) |
| wr_data | input | 16 | New base value |
| rd_sel | input | 2 | Base used for the address and for read-back |
| offset | input | 16 | Byte offset within the chosen segment |
| phys_addr | output | 20 | Physical byte address, modulo 2^20 |
| seg_value | output | 16 | Current value of the base chosen by `rd_sel` |

## Verification
Several behaviours are checked on every clocked cycle: the modular sum of base and offset on the address output, the read-back tracking the selected register, and a write touching exactly one base and only when enabled. The reset values are also checked on every edge while reset is low. Other behaviours show only in the bench's scenarios: the fixed worked examples, the wrap at the top of the 1 MB space, the old value still seen during a write cycle, and two overlapping segments giving the same address.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int SEG_W  = 16;
  localparam int OFF_W  = 16;
  localparam int SHIFT  = 4;
  localparam int ADDR_W = 20;
  localparam int NSEG   = 4;
  localparam int SEL_W  = $clog2(NSEG);

  // The select encoding is fixed: software and neighbours decode it.
  typedef enum logic [1:0] {
    SEG_EXTRA = 2'd0,
    SEG_CODE  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_DATA  = 2'd3
  } seg_sel_e;

  // Reset value of base number idx: the code base starts at the top.
  function automatic logic [SEG_W-1:0] seg_reset_value(input int idx);
    return (idx == int'(SEG_CODE)) ? {SEG_W{1'b1}} : {SEG_W{1'b0}};
  endfunction
endpackage

// File: rtl/seg_bank.sv
module seg_bank
  import seg_pkg::*;
#(
  parameter int N_REG = NSEG,
  parameter int DW    = SEG_W,
  localparam int SW   = $clog2(N_REG)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [SW-1:0]             wr_sel,
  input  logic [DW-1:0]             wr_data,
  output logic [N_REG-1:0][DW-1:0]  regs_q
);
  for (genvar g = 0; g < N_REG; g++) begin : g_reg
    localparam logic [DW-1:0] RST_VAL = DW'(seg_reset_value(g));
    logic hit;
    assign hit = wr_en && (wr_sel == SW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= RST_VAL;
      end else if (hit) begin
        regs_q[g] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/seg_addr_adder.sv
module seg_addr_adder #(
  parameter int BASE_W = 16,
  parameter int OFS_W  = 16,
  parameter int SH     = 4,
  parameter int AW     = 20,
  localparam int EXT_W = BASE_W + SH
) (
  input  logic [BASE_W-1:0] base,
  input  logic [OFS_W-1:0]  ofs,
  output logic [AW-1:0]     addr
);
  logic [EXT_W-1:0] base_scaled;
  logic [AW-1:0]    base_ext;
  logic [AW-1:0]    ofs_ext;

  always_comb begin
    base_scaled = {base, {SH{1'b0}}};
    base_ext    = AW'(base_scaled);
    ofs_ext     = AW'(ofs);
    // The carry out of the top bit drops off: the space is a ring.
    addr        = base_ext + ofs_ext;
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [SEG_W-1:0]  wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] phys_addr,
  output logic [SEG_W-1:0]  seg_value
);
  logic [NSEG-1:0][SEG_W-1:0] seg_regs;
  logic [SEG_W-1:0]           base_sel;

  seg_bank #(.N_REG(NSEG), .DW(SEG_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .regs_q  (seg_regs)
  );

  assign base_sel  = seg_regs[rd_sel];
  assign seg_value = base_sel;

  seg_addr_adder #(.BASE_W(SEG_W), .OFS_W(OFF_W), .SH(SHIFT), .AW(ADDR_W)) u_add (
    .base (base_sel),
    .ofs  (offset),
    .addr (phys_addr)
  );
endmodule

// File: rtl/seg_addr_chk.sv
module seg_addr_chk
  import seg_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic [SEL_W-1:0]           wr_sel,
  input logic [SEG_W-1:0]           wr_data,
  input logic [SEL_W-1:0]           rd_sel,
  input logic [OFF_W-1:0]           offset,
  input logic [ADDR_W-1:0]          phys_addr,
  input logic [SEG_W-1:0]           seg_value,
  input logic [NSEG-1:0][SEG_W-1:0] seg_regs
);
  // Reference sum computed from the read-back port, not from the adder.
  logic [ADDR_W-1:0] ref_addr;
  always_comb ref_addr = ADDR_W'({seg_value, {SHIFT{1'b0}}}) + ADDR_W'(offset);

  // R3: the address is the modular sum of the shown base and the offset.
  assert_addr_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr == ref_addr);

  // R2: read-back follows the select.
  assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seg_value == seg_regs[rd_sel]);

  // R5: an enabled write lands in the chosen base.
  assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> seg_regs[$past(wr_sel)] == $past(wr_data));

  // R6: nothing moves without the enable.
  assert_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(seg_regs));

  for (genvar g = 0; g < NSEG; g++) begin : g_chk
    // R7: other bases hold across a write.
    assert_others_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel != SEL_W'(g)) |=> $stable(seg_regs[g]));

    // R1: reset values while reset is held.
    always @(posedge clk) begin
      if (rst_n === 1'b0) begin
        assert_reset_value_R1: assert (seg_regs[g] == seg_reset_value(g));
      end
    end
  end
endmodule

bind seg_addr_gen seg_addr_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .rd_sel    (rd_sel),
  .offset    (offset),
  .phys_addr (phys_addr),
  .seg_value (seg_value),
  .seg_regs  (seg_regs)
);

// File: tb/tb_seg_addr_gen.sv
`timescale 1ns/1ps
module tb_seg_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'h0;
  logic [1:0]  rd_sel = 2'd0;
  logic [15:0] offset = 16'h0;
  logic [19:0] phys_addr;
  logic [15:0] seg_value;

  int checks = 0;
  int fails = 0;
  logic [15:0] model [4];

  always #2.5 clk = ~clk;

  seg_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .offset(offset),
    .phys_addr(phys_addr), .seg_value(seg_value)
  );

  function automatic logic [19:0] exp_addr(input logic [15:0] b, input logic [15:0] o);
    logic [20:0] s;
    s = {1'b0, b, 4'h0} + {5'h0, o};
    return s[19:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Set up read inputs mid-cycle and check outputs against the model.
  task automatic look(input string req, input logic [1:0] s, input logic [15:0] o);
    @(negedge clk);
    wr_en = 1'b0; rd_sel = s; offset = o;
    #1;
    chk(req, 32'(seg_value), 32'(model[s]));
    chk(req, 32'(phys_addr), 32'(exp_addr(model[s], o)));
  endtask

  task automatic write(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(posedge clk);
    model[s] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #20000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    model[0] = 16'h0000; model[1] = 16'hFFFF; model[2] = 16'h0000; model[3] = 16'h0000;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    // R1, R2: reset values per select.
    for (int i = 0; i < 4; i++) look("R1", 2'(i), 16'h0);
    @(negedge clk) rst_n = 1'b1;

    // R8: worked examples.
    write(2'd3, 16'h1005);
    look("R8", 2'd3, 16'h5555);
    chk("R8", 32'(phys_addr), 32'h155A5);
    write(2'd1, 16'h548B);
    look("R8", 2'd1, 16'h1242);
    chk("R8", 32'(phys_addr), 32'h55AF2);

    // R4: wrap at top of space.
    write(2'd2, 16'hFFFF);
    look("R4", 2'd2, 16'h0010);
    chk("R4", 32'(phys_addr), 32'h00000);
    look("R4", 2'd2, 16'hFFFF);
    chk("R4", 32'(phys_addr), 32'h0FFEF);

    // R5: old value during write cycle, new value next cycle.
    @(negedge clk);
    rd_sel = 2'd0; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'hA5A5;
    #1 chk("R5", 32'(seg_value), 32'(model[0]));
    @(posedge clk); model[0] = 16'hA5A5;
    @(negedge clk); wr_en = 1'b0;
    #1 chk("R5", 32'(seg_value), 32'hA5A5);

    // R6: disabled write ignored.
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd1; wr_data = 16'h1111;
    @(posedge clk);
    look("R6", 2'd1, 16'h0);

    // R7: single-register write leaves the rest.
    write(2'd2, 16'h7777);
    for (int i = 0; i < 4; i++) look("R7", 2'(i), 16'h0123);

    // R9: overlapping segments.
    write(2'd0, 16'h1234);
    write(2'd3, 16'h1234);
    look("R9", 2'd0, 16'h0F0F);
    look("R9", 2'd3, 16'h0F0F);
    chk("R9", 32'(phys_addr), 32'(exp_addr(16'h1234, 16'h0F0F)));

    // R3: constrained random mix.
    void'($urandom(32'd4711));
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      wr_en   = ($urandom % 3) == 0;
      wr_sel  = 2'($urandom);
      wr_data = 16'($urandom);
      rd_sel  = 2'($urandom);
      offset  = ($urandom % 8 == 0) ? 16'hFFFF : 16'($urandom);
      #1;
      chk("R3", 32'(seg_value), 32'(model[rd_sel]));
      chk("R3", 32'(phys_addr), 32'(exp_addr(model[rd_sel], offset)));
      @(posedge clk);
      if (wr_en) model[wr_sel] = wr_data;
    end
    @(negedge clk) wr_en = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule